// File: doc/BRIEF.md
# Vector Mask and Merge Unit

This unit sits beside the vector register file of a vector processor whose registers hold up to 64 elements of 64 bits. It runs two families of operation. The first family fills a 64-bit mask register, either directly from a scalar operand or by testing vector elements one at a time: a test of one source against a sign or zero condition, or a signed less-than comparison of two sources. The second family merges two source vectors into a destination, element by element, with each mask bit choosing which source supplies that element.

A caller sets the operation, the condition, the scalar operand and the vector length, then pulses `start_i`. The unit walks through the elements from index 0 upward, one per cycle. For each element it presents an index on its read port and takes both source elements back in the same cycle. For a merge it also drives the destination write port in that cycle. Elements at or beyond the vector length are never read or written. With this unit, branchy element code becomes a compare followed by a merge. For example, an element-wise minimum is a less-than compare followed by a merge.

Top module: `vmm_unit`

## Requirements
- R1: After reset `busy_o`, `done_o`, `rd_en_o` and `wr_en_o` are 0 and `mask_o` is all zeros.
- R2: Operation code 0 (scalar load) copies `scalar_i` into the mask, performs no reads or writes, and raises `done_o` in the cycle after `start_i` is sampled.
- R3: Operation code 1 (element test) sets mask bit i to the result of testing source A element i as a signed 64-bit value, with condition code 0 = equal to zero, 1 = not zero, 2 = negative (bit 63 set), 3 = positive (greater than zero).
- R4: Operation code 2 (compare) sets mask bit i to 1 exactly when source A element i is less than source B element i as signed 64-bit values.
- R5: Codes 1 and 2 clear every mask bit at or above the vector length.
- R6: Operation code 3 (merge) writes destination element i with source A element i when mask bit i is 1 and with source B element i otherwise, and leaves the mask unchanged.
- R7: Element i is read (and for a merge written) i+1 cycles after `start_i` is sampled, `busy_o` stays high for exactly vector-length cycles, and `done_o` is a one-cycle pulse in the cycle after the last element.
- R8: A vector length of 0 raises `done_o` in the cycle after start with no reads and no writes.
- R9: A vector length above 64 is treated as 64.
- R10: A `start_i` pulse while `busy_o` or `done_o` is high is ignored.
- R11: A compare (code 2) followed by a merge (code 3) of the same sources yields the element-wise signed minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only when idle |
| op_i | input | 2 | Operation code (0 load, 1 test, 2 compare, 3 merge) |
| cond_i | input | 2 | Condition code for the element test |
| vlen_i | input | 8 | Vector length; values above 64 are clamped |
| scalar_i | input | 64 | Scalar operand for the mask load |
| busy_o | output | 1 | High while elements are being processed |
| done_o | output | 1 | One-cycle completion pulse |
| rd_en_o | output | 1 | Read port enable |
| rd_idx_o | output | 6 | Element index being read |
| src_a_i | input | 64 | Source A element at `rd_idx_o` (same cycle) |
| src_b_i | input | 64 | Source B element at `rd_idx_o` (same cycle) |
| wr_en_o | output | 1 | Destination write enable |
| wr_idx_o | output | 6 | Destination element index |
| wr_data_o | output | 64 | Destination element data |
| mask_o | output | 64 | Current mask register |

## Verification
The hardest situation to reach is a new start request that arrives while an operation is still walking its elements or holding its completion pulse. If that request were taken, it would silently change the mask or the length in mid-run. The bench preloads a known mask and starts a merge. It then pulses a scalar load with the inverted mask in the middle of the run, and pulses it again in the very cycle that `done_o` is high. It checks that the mask, the write count and the cycle count are all untouched. The ends of the length range are reached directly: a length of 0, a partial length of 10, and a length of 100.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_TEST  = 2'd1,
    OP_LESS  = 2'd2,
    OP_MERGE = 2'd3
  } vmm_op_e;

  typedef enum logic [1:0] {
    CND_ZERO    = 2'd0,
    CND_NONZERO = 2'd1,
    CND_NEG     = 2'd2,
    CND_POS     = 2'd3
  } vmm_cond_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } vmm_state_e;
endpackage

// File: rtl/vmm_ctrl.sv
module vmm_ctrl
  import vmm_pkg::*;
#(
  parameter int ELEMS = 64,
  parameter int IDX_W = $clog2(ELEMS),
  parameter int VL_W  = IDX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  vmm_op_e          op_i,
  input  logic [VL_W-1:0]  vlen_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o,
  output vmm_op_e          op_o
);
  localparam logic [VL_W-1:0] LIMIT = VL_W'(ELEMS);

  vmm_state_e       state_q;
  vmm_op_e          op_q;
  logic [VL_W-1:0]  vl_q, vl_eff;
  logic [IDX_W-1:0] idx_q;
  logic             last;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign vl_eff   = (vlen_i > LIMIT) ? LIMIT : vlen_i;
  assign last     = (VL_W'(idx_q) == vl_q - VL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOAD;
      vl_q    <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          op_q  <= op_i;
          vl_q  <= vl_eff;
          idx_q <= '0;
          // scalar load and empty vectors skip the element walk
          state_q <= (op_i == OP_LOAD || vl_eff == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          if (last) state_q <= ST_DONE;
          else      idx_q   <= idx_q + IDX_W'(1);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign idx_o  = idx_q;
  assign op_o   = op_q;

  // R7
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> idx_q == $past(idx_q) + IDX_W'(1));
  // R7
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> VL_W'(idx_q) < vl_q);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || done_o) && start_i |=> $stable(vl_q) && $stable(op_q));
  // R9
  vl_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_q <= LIMIT);
endmodule

// File: rtl/vmm_cond.sv
module vmm_cond
  import vmm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  vmm_op_e           op_i,
  input  vmm_cond_e         cond_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              hit_o
);
  logic is_zero, is_neg;
  assign is_zero = (a_i == '0);
  assign is_neg  = a_i[DATA_W-1];

  always_comb begin
    if (op_i == OP_LESS) begin
      hit_o = $signed(a_i) < $signed(b_i);
    end else begin
      unique case (cond_i)
        CND_ZERO:    hit_o = is_zero;
        CND_NONZERO: hit_o = !is_zero;
        CND_NEG:     hit_o = is_neg;
        CND_POS:     hit_o = !is_neg && !is_zero;
        default:     hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/vmm_mask_reg.sv
module vmm_mask_reg #(
  parameter int ELEMS = 64,
  parameter int IDX_W = $clog2(ELEMS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ELEMS-1:0] load_val_i,
  input  logic             clr_i,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             set_val_i,
  output logic [ELEMS-1:0] mask_o
);
  for (genvar g = 0; g < ELEMS; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      bit_q <= 1'b0;
      else if (load_i)                                  bit_q <= load_val_i[g];
      else if (clr_i)                                   bit_q <= 1'b0;
      else if (set_en_i && set_idx_i == IDX_W'(g))      bit_q <= set_val_i;
    end
    assign mask_o[g] = bit_q;
  end

  // R6
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !clr_i && !set_en_i |=> $stable(mask_o));
  // R2
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> mask_o == $past(load_val_i));
endmodule

// File: rtl/vmm_unit.sv
module vmm_unit
  import vmm_pkg::*;
#(
  parameter int ELEMS  = 64,
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(ELEMS),
  parameter int VL_W   = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        cond_i,
  input  logic [VL_W-1:0]   vlen_i,
  input  logic [ELEMS-1:0]  scalar_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ELEMS-1:0]  mask_o
);
  vmm_op_e          op_q, op_in;
  vmm_cond_e        cond_q, cond_in;
  logic             accept, busy, hit, sel;
  logic [IDX_W-1:0] idx;

  assign op_in   = vmm_op_e'(op_i);
  assign cond_in = vmm_cond_e'(cond_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cond_q <= CND_ZERO;
    else if (accept) cond_q <= cond_in;
  end

  vmm_ctrl #(.ELEMS(ELEMS), .IDX_W(IDX_W), .VL_W(VL_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .op_i     (op_in),
    .vlen_i,
    .busy_o   (busy),
    .done_o,
    .accept_o (accept),
    .idx_o    (idx),
    .op_o     (op_q)
  );

  vmm_cond #(.DATA_W(DATA_W)) u_cond (
    .op_i   (op_q),
    .cond_i (cond_q),
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .hit_o  (hit)
  );

  vmm_mask_reg #(.ELEMS(ELEMS), .IDX_W(IDX_W)) u_mask (
    .clk_i, .rst_ni,
    .load_i     (accept && op_in == OP_LOAD),
    .load_val_i (scalar_i),
    .clr_i      (accept && (op_in == OP_TEST || op_in == OP_LESS)),
    .set_en_i   (busy && (op_q == OP_TEST || op_q == OP_LESS)),
    .set_idx_i  (idx),
    .set_val_i  (hit),
    .mask_o
  );

  assign sel       = mask_o[idx];
  assign busy_o    = busy;
  assign rd_en_o   = busy;
  assign rd_idx_o  = idx;
  assign wr_en_o   = busy && (op_q == OP_MERGE);
  assign wr_idx_o  = idx;
  assign wr_data_o = sel ? src_a_i : src_b_i;

  // R6
  merge_mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> $stable(mask_o));
  // R8
  no_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wr_en_o && !rd_en_o);
endmodule

// File: tb/vmm_unit_bench.sv
module vmm_unit_bench;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  op = '0, cond = '0;
  logic [7:0]  vlen = '0;
  logic [63:0] scalar = '0;
  logic        busy, done, rd_en, wr_en;
  logic [5:0]  rd_idx, wr_idx;
  logic [63:0] src_a, src_b, wr_data, mask;
  logic [63:0] va [64];
  logic [63:0] vb [64];
  logic [63:0] dest [64];
  int n_wr, n_rd, checks, errors;

  always #2 clk = ~clk;

  assign src_a = va[rd_idx];
  assign src_b = vb[rd_idx];

  vmm_unit u_vmm_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .cond_i(cond),
    .vlen_i(vlen), .scalar_i(scalar), .busy_o(busy), .done_o(done),
    .rd_en_o(rd_en), .rd_idx_o(rd_idx), .src_a_i(src_a), .src_b_i(src_b),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .mask_o(mask)
  );

  always @(negedge clk) begin
    if (wr_en) begin dest[wr_idx] = wr_data; n_wr++; end
    if (rd_en) n_rd++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit test_fn(input logic [1:0] c, input logic [63:0] a);
    case (c)
      2'd0: return a == 0;
      2'd1: return a != 0;
      2'd2: return $signed(a) < 0;
      default: return $signed(a) > 0;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [1:0] c, input logic [7:0] vl,
                        input logic [63:0] sc, output int cyc);
    @(negedge clk);
    n_wr = 0; n_rd = 0;
    op = o; cond = c; vlen = vl; scalar = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 300) begin @(negedge clk); cyc++; end
    if (!done) chk(0, "watchdog", 64'(cyc), 64'd0);
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    chk(!rd_en && !wr_en, "R1 ports", {rd_en, wr_en}, 0);
    chk(mask == 0, "R1 mask", mask, 0);
  endtask

  task automatic t_scalar();
    int cyc;
    run_op(2'd0, 2'd0, 8'd64, 64'hA5C3_0F0F_1234_8001, cyc);
    chk(mask == 64'hA5C3_0F0F_1234_8001, "R2 mask", mask, 64'hA5C3_0F0F_1234_8001);
    chk(cyc == 0, "R2 latency", 64'(cyc), 0);
    chk(n_rd == 0 && n_wr == 0, "R2 no access", 64'(n_rd + n_wr), 0);
  endtask

  task automatic t_test();
    int cyc;
    logic [63:0] exp;
    for (int c = 0; c < 4; c++) begin
      exp = '0;
      for (int i = 0; i < 64; i++) exp[i] = test_fn(2'(c), va[i]);
      run_op(2'd1, 2'(c), 8'd64, 64'hFFFF_FFFF_FFFF_FFFF, cyc);
      chk(mask == exp, $sformatf("R3 cond %0d", c), mask, exp);
    end
    run_op(2'd0, 2'd0, 8'd0, '1, cyc);
    exp = '0;
    for (int i = 0; i < 10; i++) exp[i] = test_fn(2'd1, va[i]);
    run_op(2'd1, 2'd1, 8'd10, '0, cyc);
    chk(mask == exp, "R5 upper bits cleared", mask, exp);
    chk(cyc == 10 && n_rd == 10, "R7 partial length", 64'(cyc), 10);
  endtask

  task automatic t_less();
    int cyc;
    logic [63:0] exp = '0;
    for (int i = 0; i < 64; i++) exp[i] = $signed(va[i]) < $signed(vb[i]);
    run_op(2'd2, 2'd0, 8'd64, '0, cyc);
    chk(mask == exp, "R4 less-than mask", mask, exp);
  endtask

  task automatic t_merge();
    int cyc;
    bit ok = 1;
    logic [63:0] m = 64'h0123_4567_89AB_CDEF;
    run_op(2'd0, 2'd0, 8'd0, m, cyc);
    for (int i = 0; i < 64; i++) dest[i] = 64'hDEAD_BEEF_0000_0000 | 64'(i);
    run_op(2'd3, 2'd0, 8'd20, '0, cyc);
    for (int i = 0; i < 20; i++)
      if (dest[i] !== (m[i] ? va[i] : vb[i])) ok = 0;
    chk(ok, "R6 merged data", dest[0], m[0] ? va[0] : vb[0]);
    ok = 1;
    for (int i = 20; i < 64; i++) if (dest[i] !== (64'hDEAD_BEEF_0000_0000 | 64'(i))) ok = 0;
    chk(ok, "R6 tail untouched", dest[20], 64'hDEAD_BEEF_0000_0014);
    chk(mask == m, "R6 mask kept", mask, m);
    chk(cyc == 20 && n_wr == 20, "R7 busy span", 64'(cyc), 20);
  endtask

  task automatic t_zero_len();
    int cyc;
    run_op(2'd3, 2'd0, 8'd0, '0, cyc);
    chk(cyc == 0, "R8 immediate done", 64'(cyc), 0);
    chk(n_wr == 0 && n_rd == 0, "R8 no access", 64'(n_wr + n_rd), 0);
  endtask

  task automatic t_clamp();
    int cyc;
    run_op(2'd3, 2'd0, 8'd100, '0, cyc);
    chk(cyc == 64 && n_wr == 64, "R9 clamp", 64'(n_wr), 64);
  endtask

  task automatic t_ignore();
    int cyc;
    logic [63:0] m = 64'h00FF_F00F_3C3C_5A5A;
    run_op(2'd0, 2'd0, 8'd0, m, cyc);
    @(negedge clk);
    n_wr = 0;
    op = 2'd3; vlen = 8'd12; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 0;
    while (!done && cyc < 300) begin
      if (cyc == 3) begin op = 2'd0; scalar = ~m; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    chk(cyc == 12 && n_wr == 12, "R10 mid-run start", 64'(cyc), 12);
    op = 2'd0; scalar = ~m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mask == m, "R10 mask untouched", mask, m);
    @(negedge clk);
    chk(!done && !busy, "R10 no new run", {busy, done}, 0);
  endtask

  task automatic t_min();
    int cyc;
    bit ok = 1;
    logic [63:0] e;
    run_op(2'd2, 2'd0, 8'd64, '0, cyc);
    run_op(2'd3, 2'd0, 8'd64, '0, cyc);
    for (int i = 0; i < 64; i++) begin
      e = ($signed(va[i]) < $signed(vb[i])) ? va[i] : vb[i];
      if (dest[i] !== e) ok = 0;
    end
    chk(ok, "R11 minimum", dest[5], ($signed(va[5]) < $signed(vb[5])) ? va[5] : vb[5]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      case (i % 4)
        0: va[i] = 64'd0;
        1: va[i] = 64'(i * 3);
        2: va[i] = -64'(i);
        default: va[i] = 64'h8000_0000_0000_0000 | 64'(i);
      endcase
      vb[i] = 64'(i * 7) - 64'd200;
      dest[i] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_scalar();
    t_test();
    t_less();
    t_merge();
    t_zero_len();
    t_clamp();
    t_ignore();
    t_min();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule